// File: doc/BRIEF.md
# Mersenne Residue Folding Reducer

The block turns an unsigned binary word of `IN_W` bits into its residue modulo the Mersenne number 2^`RES_W` − 1. It needs no divider and no comparator. Because 2^`RES_W` is congruent to 1 for this modulus, the bits above position `RES_W`−1 can be removed from their place and added back at the bottom. The block cuts the word at bit `RES_W` and adds the upper part to the lower part. It repeats this until nothing is left above the cut. A carry out of one addition becomes an upper bit, and the next fold puts it back in at the bottom, which gives the end-around-carry behaviour of a Mersenne adder.

A controller uses the block by pulsing `in_valid` together with a word while the block is idle. The block captures the word and folds it once per clock. When the word fits in `RES_W` bits, the block raises `out_valid` for one cycle with the residue. A pattern of all ones in `RES_W` bits means zero, so the reported residue is never all ones. With the default sizes, a 5-bit word needs at most one carry-generating fold before it settles. Wider words simply take more clocks.

The controller has three states. `ST_IDLE` waits for `in_valid`; the transition *capture* loads the word and moves to `ST_FOLD`. `ST_FOLD` either takes the *fold* transition back to itself while upper bits remain, or takes the *settle* transition to `ST_DONE` and writes the residue. `ST_DONE` presents `out_valid` and takes the *release* transition back to `ST_IDLE`.

Top module: `mersenne_fold_reducer`

## Requirements
- R1: While `rst_n` is low and after reset, `out_valid` is 0 and `out_residue` is 0.
- R2: A high `in_valid` seen at a clock edge while idle starts one conversion. It produces exactly one `out_valid` pulse, one cycle wide.
- R3: `out_residue` is never all ones while `out_valid` is high, because the all-ones pattern is reported as 0.
- R4: With `out_valid` high, `out_residue` equals the captured word modulo 2^`RES_W` − 1, for every input value.
- R5: Each clock in `ST_FOLD` with nonzero upper bits replaces the value by its low `RES_W` bits plus its remaining upper bits. If N such folds are needed, `out_valid` is high in the cycle after the (N+1)-th clock edge that follows the capturing edge.
- R6: `in_valid` is ignored while a conversion is in progress or being reported. Such a word yields no result, and the running result is unchanged.
- R7: For `RES_W`=3 and `IN_W`=5, the inputs 27, 31, 21 and 29 give the residues 6, 3, 0 and 1.
- R8: `out_residue` holds its value except in the cycle a new result is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Start pulse; the word is captured when the block is idle |
| in_value | input | IN_W | Unsigned binary word to reduce |
| out_valid | output | 1 | One-cycle pulse marking a new residue |
| out_residue | output | RES_W | Residue modulo 2^RES_W − 1, in the range 0 to 2^RES_W − 2 |

## Verification
The checker assumes that reset is applied before the first conversion. It also assumes that `IN_W` is larger than `RES_W`, so at least one upper bit exists. The checker follows conversions at the ports alone. It marks a conversion pending when `in_valid` arrives with none outstanding, and clears the mark on `out_valid`. This mark is valid only because the block refuses words while busy, so the stimulus includes a start pulse issued in the middle of a conversion to test that refusal. The bench otherwise gives each word as a single-cycle pulse and waits for its result before it sends the next one, so the checker's mark always matches a real conversion.

// File: rtl/mfold_pkg.sv
package mfold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FOLD = 2'd1,
        ST_DONE = 2'd2
    } fold_state_e;
endpackage

// File: rtl/mfold_step.sv
// One fold: cut at bit RES_W and add the upper part back onto the lower part.
module mfold_step #(
    parameter int IN_W  = 5,
    parameter int RES_W = 3
) (
    input  logic [IN_W-1:0] acc_i,
    output logic [IN_W-1:0] next_o,
    output logic            fits_o
);
    localparam int HI_W = IN_W - RES_W;

    logic [RES_W-1:0] low_part;
    logic [HI_W-1:0]  high_part;

    always_comb begin
        low_part  = acc_i[RES_W-1:0];
        high_part = acc_i[IN_W-1:RES_W];
        fits_o    = (high_part == '0);
        // A carry lands above the cut and is reabsorbed by the next fold.
        next_o    = {{HI_W{1'b0}}, low_part} + {{RES_W{1'b0}}, high_part};
    end
endmodule

// File: rtl/mfold_final.sv
// The all-ones pattern is congruent to zero and is reported as zero.
module mfold_final #(
    parameter int RES_W = 3
) (
    input  logic [RES_W-1:0] val_i,
    output logic [RES_W-1:0] res_o
);
    always_comb begin
        res_o = (&val_i) ? '0 : val_i;
    end
endmodule

// File: rtl/mersenne_fold_reducer.sv
module mersenne_fold_reducer #(
    parameter int IN_W  = 5,
    parameter int RES_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_value,
    output logic             out_valid,
    output logic [RES_W-1:0] out_residue
);
    import mfold_pkg::*;

    fold_state_e      state_q;
    fold_state_e      state_d;
    logic [IN_W-1:0]  acc_q;
    logic [IN_W-1:0]  acc_next;
    logic             acc_fits;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] res_final;

    mfold_step #(.IN_W(IN_W), .RES_W(RES_W)) u_step (
        .acc_i  (acc_q),
        .next_o (acc_next),
        .fits_o (acc_fits)
    );

    mfold_final #(.RES_W(RES_W)) u_final (
        .val_i (acc_q[RES_W-1:0]),
        .res_o (res_final)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: capture, fold, settle, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_FOLD;
            ST_FOLD: if (acc_fits) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) acc_q <= in_value;
                ST_FOLD: begin
                    if (acc_fits) res_q <= res_final;
                    else          acc_q <= acc_next;
                end
                default: ;
            endcase
        end
    end

    assign out_valid   = (state_q == ST_DONE);
    assign out_residue = res_q;
endmodule

// File: rtl/mersenne_fold_reducer_chk.sv
module mersenne_fold_reducer_chk #(
    parameter int RES_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [RES_W-1:0] out_residue
);
    logic pending_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pending_q <= 1'b0;
        else if (out_valid)              pending_q <= 1'b0;
        else if (in_valid && !pending_q) pending_q <= 1'b1;
    end

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_result_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pending_q);

    assert_no_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_residue != '1));

    assert_residue_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_residue) |-> out_valid);
endmodule

bind mersenne_fold_reducer mersenne_fold_reducer_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_residue (out_residue)
);

// File: tb/test_mersenne_fold_reducer.sv
module test_mersenne_fold_reducer;
    localparam int IN_W  = 5;
    localparam int RES_W = 3;
    localparam int MODV  = (1 << RES_W) - 1;
    localparam int NVEC  = 7;
    localparam int VIN  [NVEC] = '{27, 31, 21, 29, 0, 7, 14};
    localparam int VRES [NVEC] = '{ 6,  3,  0,  1, 0, 0, 0};
    localparam int VLAT [NVEC] = '{ 2,  3,  2,  3, 1, 1, 2};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_value = '0;
    logic             out_valid;
    logic [RES_W-1:0] out_residue;
    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mersenne_fold_reducer #(.IN_W(IN_W), .RES_W(RES_W)) i_mersenne_fold_reducer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .out_valid(out_valid), .out_residue(out_residue));

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles until out_valid, per the fold count defined in R5
    function automatic int ref_lat(input int v);
        int n = 1;
        while (v >= (1 << RES_W)) begin
            v = (v % (1 << RES_W)) + (v / (1 << RES_W));
            n++;
        end
        return n;
    endfunction

    task automatic run(input int v, output int res, output int lat);
        @(negedge clk);
        in_valid = 1'b1;
        in_value = IN_W'(v);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        res = int'(out_residue);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int res, lat;
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 residue in reset", int'(out_residue), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);

        // R7 R5: stated vectors with latency
        for (int i = 0; i < NVEC; i++) begin
            run(VIN[i], res, lat);
            check("R7 residue", res, VRES[i]);
            check("R5 latency", lat, VLAT[i]);
            @(negedge clk);
            check("R2 pulse width", int'(out_valid), 0);
            check("R8 residue held", int'(out_residue), VRES[i]);
        end

        // R4 R3 R5: every input value
        for (int v = 0; v < (1 << IN_W); v++) begin
            run(v, res, lat);
            check("R4 residue", res, v % MODV);
            check("R3 not all ones", int'(res == MODV), 0);
            check("R5 latency", lat, ref_lat(v));
        end

        // R6: start pulse during a running conversion is ignored
        @(negedge clk);
        in_valid = 1'b1;
        in_value = IN_W'(31);
        @(negedge clk);
        in_value = IN_W'(13);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R6 running result kept", int'(out_residue), 3);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R6 no extra result", int'(out_valid), 0);
        end

        // R1: reset in the middle of a conversion
        @(negedge clk);
        in_valid = 1'b1;
        in_value = IN_W'(29);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid mid reset", int'(out_valid), 0);
        check("R1 residue mid reset", int'(out_residue), 0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R1 no result after reset", int'(out_valid), 0);
        end
        run(22, res, lat);
        check("R4 after reset", res, 22 % MODV);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule